// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit linear address into a physical page frame by reading 64-bit table entries from memory. The hierarchy has four levels with 512 entries each. Level 3 is the top level and level 0 holds the page-table entries. A walk can stop early at level 2 or level 1 when the entry's page-size bit is set, and the result is then a 1 GiB or 2 MiB page. The response carries the frame, the mask of linear-address bits that pass through unchanged as the page offset, the global flag of the leaf entry, and a fault flag with an error code.

A client starts a walk with a valid/ready request that holds the linear address and the table root. Only one walk runs at a time, so `req_ready` is high only while the walker is idle. Back-pressure applies to the memory port. A memory request is held with the same address, data and direction until `mem_req_ready` is seen high at a clock edge. A read returns its data through a one-cycle `mem_rsp_valid`. Writes are posted and get no response. The walk result comes back as a one-cycle `rsp_valid` pulse and cannot be stalled. A successful walk then writes back the accessed bit of every entry above the leaf that had it clear.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0. `req_ready` is 1 only while idle, so a second request is not taken until the previous walk has produced its response. `rsp_valid` is high for exactly one cycle per walk.
- R2: The walk reads level 3 first and then goes down one level per read. The entry address is base + 8 × ((linear >> (12 + 9 × level)) & 511). The first base is the root with its low 12 bits cleared.
- R3: For a present non-leaf entry, the base used at the next level is the entry ANDed with 0x000FFFFFFFFFF000, truncated to the physical address width.
- R4: A present level-0 entry ends the walk without a fault. The frame is the entry ANDed with 0x000FFFFFFFFFF000, and the mask is 0xFFF.
- R5: A level-1 entry with bit 7 set is a 2 MiB leaf. If any of entry bits 20..13 is set, the walk faults with code 0x9. Otherwise the frame is entry bits [PA_W-1:21] joined with linear bits 20..12 and 12 zero bits, and the mask is 0x1FFFFF.
- R6: A level-2 entry with bit 7 set is a 1 GiB leaf when `EN_1G`=1. If any of entry bits 29..13 is set, the walk faults with code 0x9. Otherwise the frame is entry bits [PA_W-1:30] joined with linear bits 29..12 and 12 zero bits, and the mask is 0x3FFFFFFF. When `EN_1G`=0, bit 7 set at level 2 faults with code 0x9.
- R7: A level-3 entry with bit 7 set faults with code 0x9.
- R8: An entry with bit 0 clear ends the walk with a fault and code 0x0, and no memory write is issued for that walk.
- R9: A present entry with any bit from PA_W to 51 set faults with code 0x9. In the error code, bit 0 means the faulting entry was present and bit 3 means a reserved bit was set.
- R10: `rsp_global` equals bit 8 of the leaf entry.
- R11: After a successful walk, every level above the leaf whose entry has bit 5 clear is written back to the address it was read from. The written value is the entry with bit 5 set. Writes go from the top level downward. Entries that already had bit 5 set, and the leaf entry itself, are not written.
- R12: A memory request that meets `mem_req_ready` low stays valid on the next cycle with the same address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_laddr | input | 48 | Linear address to translate |
| req_root | input | PA_W | Root table base; low 12 bits ignored |
| mem_req_valid | output | 1 | Memory access request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for accessed-bit write-back, 0 for entry read |
| mem_req_addr | output | PA_W | Byte address of the 64-bit entry |
| mem_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_frame | output | PA_W | Physical frame base, 4 KiB aligned; 0 on fault |
| rsp_mask | output | 30 | Page offset mask |
| rsp_global | output | 1 | Global flag of the leaf entry |
| rsp_fault | output | 1 | Walk faulted |
| rsp_err | output | 4 | Error code: bit 0 present, bit 3 reserved |

## Verification
The main instance is built with PA_W=40 and `EN_1G`=1. The narrow physical width makes entry bits 40..51 reserved, so the high-reserved fault can be reached. The same instance also covers 4 KiB, 2 MiB and 1 GiB leaves. A second instance with `EN_1G`=0 checks that the page-size bit at level 2 faults when large pages of that size are disabled. Each bench memory model accepts requests only on alternate cycles, so every walk runs under memory back-pressure.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int LA_W     = 48;
  localparam int PG_SHIFT = 12;
  localparam int IDX_W    = 9;
  localparam int LEVELS   = 4;
  localparam int LVL_W    = 2;
  localparam int ENTRY_W  = 64;
  localparam int MASK_W   = 30;
  localparam int ERR_W    = 4;
  localparam int LA_PG_W  = LA_W - PG_SHIFT;

  localparam int BIT_PRES = 0;
  localparam int BIT_ACC  = 5;
  localparam int BIT_SIZE = 7;
  localparam int BIT_GLB  = 8;

  localparam logic [ERR_W-1:0] ERR_PRESENT  = 4'h1;
  localparam logic [ERR_W-1:0] ERR_RESERVED = 4'h8;

  localparam logic [MASK_W-1:0] MASK_4K = 30'h0000_0FFF;
  localparam logic [MASK_W-1:0] MASK_2M = 30'h001F_FFFF;
  localparam logic [MASK_W-1:0] MASK_1G = 30'h3FFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WB_SCAN,
    ST_WB_REQ,
    ST_RESP
  } walk_state_t;

  typedef enum logic [1:0] {
    DEC_NEXT,
    DEC_LEAF,
    DEC_FAULT
  } dec_kind_t;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic [PA_W-1:0]    base,
  input  logic [LA_PG_W-1:0] la_pg,
  input  logic [LVL_W-1:0]   level,
  output logic [PA_W-1:0]    ent_addr
);
  localparam int OFS_W = IDX_W + 3;

  logic [IDX_W-1:0] idx_tab [LEVELS];

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_idx
      assign idx_tab[g] = la_pg[IDX_W*g +: IDX_W];
    end
  endgenerate

  logic [OFS_W-1:0] ofs;
  assign ofs      = {idx_tab[level], 3'b000};
  assign ent_addr = base + {{(PA_W-OFS_W){1'b0}}, ofs};
endmodule

// File: rtl/pw_entry_decode.sv
module pw_entry_decode
  import pw_pkg::*;
#(
  parameter int PA_W  = 52,
  parameter bit EN_1G = 1'b1
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [LVL_W-1:0]   level,
  input  logic [17:0]        la_lo,
  output dec_kind_t          kind,
  output logic [ERR_W-1:0]   err,
  output logic [PA_W-1:0]    next_base,
  output logic [PA_W-1:0]    frame,
  output logic [MASK_W-1:0]  mask
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  logic hi_rsvd;
  generate
    if (PA_W < 52) begin : g_hi
      assign hi_rsvd = |entry[51:PA_W];
    end else begin : g_nohi
      assign hi_rsvd = 1'b0;
    end
  endgenerate

  logic [PA_W-1:0] frame_4k, frame_2m, frame_1g;
  assign frame_4k = {entry[PA_W-1:12], 12'b0};
  assign frame_2m = {entry[PA_W-1:21], la_lo[8:0], 12'b0};
  assign frame_1g = {entry[PA_W-1:30], la_lo[17:0], 12'b0};

  logic unused_dec;
  assign unused_dec = ^{entry[63:52], entry[11:8], entry[6:1]};

  logic large_off;
  assign large_off = (level == TOP_LVL) || ((level == 2'd2) && !EN_1G);

  always_comb begin
    kind  = DEC_NEXT;
    err   = '0;
    frame = frame_4k;
    mask  = MASK_4K;
    if (!entry[BIT_PRES]) begin
      kind = DEC_FAULT;
    end else if (hi_rsvd) begin
      kind = DEC_FAULT;
      err  = ERR_PRESENT | ERR_RESERVED;
    end else if (level == 2'd0) begin
      kind = DEC_LEAF;
    end else if (entry[BIT_SIZE]) begin
      if (large_off) begin
        kind = DEC_FAULT;
        err  = ERR_PRESENT | ERR_RESERVED;
      end else if (level == 2'd2) begin
        if (|entry[29:13]) begin
          kind = DEC_FAULT;
          err  = ERR_PRESENT | ERR_RESERVED;
        end else begin
          kind  = DEC_LEAF;
          frame = frame_1g;
          mask  = MASK_1G;
        end
      end else begin
        if (|entry[20:13]) begin
          kind = DEC_FAULT;
          err  = ERR_PRESENT | ERR_RESERVED;
        end else begin
          kind  = DEC_LEAF;
          frame = frame_2m;
          mask  = MASK_2M;
        end
      end
    end
  end

  assign next_base = frame_4k;
endmodule

// File: rtl/pw_entry_store.sv
module pw_entry_store
  import pw_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [LVL_W-1:0]   wr_lvl,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic [PA_W-1:0]    wr_addr,
  input  logic [LVL_W-1:0]   rd_lvl,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic [PA_W-1:0]    rd_addr,
  output logic [LEVELS-1:0]  acc_clear
);
  logic [ENTRY_W-1:0] ent_q  [LEVELS];
  logic [PA_W-1:0]    addr_q [LEVELS];

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q[g]  <= '0;
          addr_q[g] <= '0;
        end else if (we && (wr_lvl == LVL_W'(g))) begin
          ent_q[g]  <= wr_entry;
          addr_q[g] <= wr_addr;
        end
      end
      assign acc_clear[g] = !ent_q[g][BIT_ACC];
    end
  endgenerate

  assign rd_entry = ent_q[rd_lvl];
  assign rd_addr  = addr_q[rd_lvl];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int PA_W  = 52,
  parameter bit EN_1G = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LA_W-1:0]    req_laddr,
  input  logic [PA_W-1:0]    req_root,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic [ENTRY_W-1:0] mem_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rdata,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_frame,
  output logic [MASK_W-1:0]  rsp_mask,
  output logic               rsp_global,
  output logic               rsp_fault,
  output logic [ERR_W-1:0]   rsp_err
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);
  localparam logic [ENTRY_W-1:0] ACC_SET = ENTRY_W'(1) << BIT_ACC;

  walk_state_t          st_q;
  logic [LVL_W-1:0]     lvl_q, leaf_q, wb_q;
  logic [PA_W-1:0]      base_q, frame_q;
  logic [LA_PG_W-1:0]   la_q;
  logic [MASK_W-1:0]    mask_q;
  logic                 glb_q, flt_q;
  logic [ERR_W-1:0]     err_q;

  logic [PA_W-1:0]      ent_addr;
  dec_kind_t            dec_kind;
  logic [ERR_W-1:0]     dec_err;
  logic [PA_W-1:0]      dec_next, dec_frame;
  logic [MASK_W-1:0]    dec_mask;
  logic [ENTRY_W-1:0]   st_entry;
  logic [PA_W-1:0]      st_addr;
  logic [LEVELS-1:0]    acc_clear;
  logic                 store_we;

  logic unused_top;
  assign unused_top = ^req_root[11:0];

  pw_addr_gen #(.PA_W(PA_W)) u_addr (
    .base     (base_q),
    .la_pg    (la_q),
    .level    (lvl_q),
    .ent_addr (ent_addr)
  );

  pw_entry_decode #(.PA_W(PA_W), .EN_1G(EN_1G)) u_dec (
    .entry     (mem_rdata),
    .level     (lvl_q),
    .la_lo     (la_q[17:0]),
    .kind      (dec_kind),
    .err       (dec_err),
    .next_base (dec_next),
    .frame     (dec_frame),
    .mask      (dec_mask)
  );

  assign store_we = (st_q == ST_RD_WAIT) && mem_rsp_valid;

  pw_entry_store #(.PA_W(PA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (store_we),
    .wr_lvl    (lvl_q),
    .wr_entry  (mem_rdata),
    .wr_addr   (ent_addr),
    .rd_lvl    (wb_q),
    .rd_entry  (st_entry),
    .rd_addr   (st_addr),
    .acc_clear (acc_clear)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      leaf_q  <= '0;
      wb_q    <= '0;
      base_q  <= '0;
      la_q    <= '0;
      frame_q <= '0;
      mask_q  <= '0;
      glb_q   <= 1'b0;
      flt_q   <= 1'b0;
      err_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            la_q   <= req_laddr[LA_W-1:PG_SHIFT];
            base_q <= {req_root[PA_W-1:12], 12'b0};
            lvl_q  <= TOP_LVL;
            st_q   <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (mem_req_ready) st_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            case (dec_kind)
              DEC_FAULT: begin
                flt_q   <= 1'b1;
                err_q   <= dec_err;
                frame_q <= '0;
                mask_q  <= '0;
                glb_q   <= 1'b0;
                st_q    <= ST_RESP;
              end
              DEC_LEAF: begin
                flt_q   <= 1'b0;
                err_q   <= '0;
                frame_q <= dec_frame;
                mask_q  <= dec_mask;
                glb_q   <= mem_rdata[BIT_GLB];
                leaf_q  <= lvl_q;
                wb_q    <= TOP_LVL;
                st_q    <= ST_WB_SCAN;
              end
              default: begin
                base_q <= dec_next;
                lvl_q  <= lvl_q - 1'b1;
                st_q   <= ST_RD_REQ;
              end
            endcase
          end
        end
        ST_WB_SCAN: begin
          if (wb_q == leaf_q)          st_q <= ST_RESP;
          else if (acc_clear[wb_q])    st_q <= ST_WB_REQ;
          else                         wb_q <= wb_q - 1'b1;
        end
        ST_WB_REQ: begin
          if (mem_req_ready) begin
            wb_q <= wb_q - 1'b1;
            st_q <= ST_WB_SCAN;
          end
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_RD_REQ) || (st_q == ST_WB_REQ);
  assign mem_req_write = (st_q == ST_WB_REQ);
  assign mem_req_addr  = mem_req_write ? st_addr : ent_addr;
  assign mem_wdata     = st_entry | ACC_SET;

  assign rsp_valid  = (st_q == ST_RESP);
  assign rsp_frame  = frame_q;
  assign rsp_mask   = mask_q;
  assign rsp_global = glb_q;
  assign rsp_fault  = flt_q;
  assign rsp_err    = err_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            wr_abit,
  input logic            rsp_valid,
  input logic [11:0]     rsp_frame_lo,
  input logic [29:0]     rsp_mask,
  input logic            rsp_fault,
  input logic [3:0]      rsp_err
);
  logic wrote_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        wrote_q <= 1'b0;
    else if (req_valid && req_ready)                   wrote_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready && mem_req_write) wrote_q <= 1'b1;
  end

  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  assert_abit_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> wr_abit);

  assert_no_wb_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !wrote_q);

  assert_mask_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |->
      ((rsp_mask == 30'h0000_0FFF) || (rsp_mask == 30'h001F_FFFF) ||
       (rsp_mask == 30'h3FFF_FFFF)));

  assert_frame_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_frame_lo == 12'h000));

  assert_err_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> ((rsp_err == 4'h0) || (rsp_err == 4'h9)));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .wr_abit       (mem_wdata[5]),
  .rsp_valid     (rsp_valid),
  .rsp_frame_lo  (rsp_frame[11:0]),
  .rsp_mask      (rsp_mask),
  .rsp_fault     (rsp_fault),
  .rsp_err       (rsp_err)
);

// File: tb/pt_walker_tb.sv
module pw_mem_model #(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_req_valid,
  output logic          mem_req_ready,
  input  logic          mem_req_write,
  input  logic [AW-1:0] mem_req_addr,
  input  logic [63:0]   mem_wdata,
  output logic          mem_rsp_valid,
  output logic [63:0]   mem_rdata
);
  logic [63:0] store [longint];
  longint wr_log [$];
  logic tick;

  function automatic void poke(longint a, logic [63:0] d);
    store[a] = d;
  endfunction

  function automatic logic [63:0] peek(longint a);
    if (store.exists(a)) return store[a];
    return 64'h0;
  endfunction

  function automatic void clear();
    store.delete();
    wr_log.delete();
  endfunction

  function automatic int wr_count();
    return wr_log.size();
  endfunction

  function automatic longint wr_at(int i);
    return wr_log[i];
  endfunction

  assign mem_req_ready = tick;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick          <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rdata     <= '0;
    end else begin
      tick          <= !tick;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          store[longint'(mem_req_addr)] = mem_wdata;
          wr_log.push_back(longint'(mem_req_addr));
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rdata     <= peek(longint'(mem_req_addr));
        end
      end
    end
  end
endmodule

module pt_walker_tb;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = !clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [47:0]     laddr_i = '0;
  logic [PA_W-1:0] root_i  = '0;
  logic rv1 = 1'b0, rv2 = 1'b0;

  logic rr1, rr2, mv1, mv2, mrdy1, mrdy2, mw1, mw2, mrv1, mrv2;
  logic [PA_W-1:0] ma1, ma2, fr1, fr2;
  logic [63:0] wd1, wd2, rd1, rd2;
  logic rs1, rs2, gl1, gl2, ft1, ft2;
  logic [29:0] mk1, mk2;
  logic [3:0] er1, er2;

  pt_walker #(.PA_W(PA_W), .EN_1G(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv1), .req_ready(rr1),
    .req_laddr(laddr_i), .req_root(root_i),
    .mem_req_valid(mv1), .mem_req_ready(mrdy1), .mem_req_write(mw1),
    .mem_req_addr(ma1), .mem_wdata(wd1), .mem_rsp_valid(mrv1), .mem_rdata(rd1),
    .rsp_valid(rs1), .rsp_frame(fr1), .rsp_mask(mk1), .rsp_global(gl1),
    .rsp_fault(ft1), .rsp_err(er1)
  );

  pw_mem_model #(.AW(PA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .mem_req_valid(mv1), .mem_req_ready(mrdy1),
    .mem_req_write(mw1), .mem_req_addr(ma1), .mem_wdata(wd1),
    .mem_rsp_valid(mrv1), .mem_rdata(rd1)
  );

  pt_walker #(.PA_W(PA_W), .EN_1G(1'b0)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv2), .req_ready(rr2),
    .req_laddr(laddr_i), .req_root(root_i),
    .mem_req_valid(mv2), .mem_req_ready(mrdy2), .mem_req_write(mw2),
    .mem_req_addr(ma2), .mem_wdata(wd2), .mem_rsp_valid(mrv2), .mem_rdata(rd2),
    .rsp_valid(rs2), .rsp_frame(fr2), .rsp_mask(mk2), .rsp_global(gl2),
    .rsp_fault(ft2), .rsp_err(er2)
  );

  pw_mem_model #(.AW(PA_W)) u_mem2 (
    .clk(clk), .rst_n(rst_n), .mem_req_valid(mv2), .mem_req_ready(mrdy2),
    .mem_req_write(mw2), .mem_req_addr(ma2), .mem_wdata(wd2),
    .mem_rsp_valid(mrv2), .mem_rdata(rd2)
  );

  // captured results of the last walk
  logic [PA_W-1:0] got_frame;
  logic [29:0]     got_mask;
  logic            got_glb, got_flt, got_busy_ready, got_after;
  logic [3:0]      got_err;

  // back-pressure monitor on the main instance (R12)
  int   hold_err = 0;
  int   stall_seen = 0;
  logic prev_stall = 1'b0;
  logic [PA_W-1:0] prev_addr = '0;
  logic prev_wr = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && !(mv1 && ma1 == prev_addr && mw1 == prev_wr)) hold_err++;
      prev_stall = mv1 && !mrdy1;
      if (prev_stall) stall_seen++;
      prev_addr = ma1;
      prev_wr   = mw1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  function automatic logic [PA_W-1:0] ea(input logic [PA_W-1:0] base,
                                         input logic [47:0] la, input int lvl);
    return base + PA_W'(((la >> (12 + 9 * lvl)) & 48'h1ff) << 3);
  endfunction

  localparam logic [PA_W-1:0] B3 = 40'h1000, B2 = 40'h2000, B1 = 40'h3000, B0 = 40'h4000;
  localparam logic [47:0] LA = 48'h1234_5678_9abc;

  task automatic build(input bit sel, input logic [63:0] e3, e2, e1, e0);
    if (sel) begin
      u_mem2.clear();
      u_mem2.poke(longint'(ea(B3, LA, 3)), e3);
      u_mem2.poke(longint'(ea(B2, LA, 2)), e2);
      u_mem2.poke(longint'(ea(B1, LA, 1)), e1);
      u_mem2.poke(longint'(ea(B0, LA, 0)), e0);
    end else begin
      u_mem.clear();
      u_mem.poke(longint'(ea(B3, LA, 3)), e3);
      u_mem.poke(longint'(ea(B2, LA, 2)), e2);
      u_mem.poke(longint'(ea(B1, LA, 1)), e1);
      u_mem.poke(longint'(ea(B0, LA, 0)), e0);
    end
  endtask

  task automatic walk(input bit sel);
    int guard = 0;
    @(negedge clk);
    laddr_i = LA;
    root_i  = B3 | 40'h0a5;  // low bits must be ignored
    if (sel) rv2 = 1'b1; else rv1 = 1'b1;
    while (!(sel ? rr2 : rr1)) @(negedge clk);
    @(negedge clk);
    rv1 = 1'b0;
    rv2 = 1'b0;
    got_busy_ready = sel ? rr2 : rr1;
    while (!(sel ? rs2 : rs1) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 2000, "R1 walk completes", 64'(guard), 64'd2000);
    got_frame = sel ? fr2 : fr1;
    got_mask  = sel ? mk2 : mk1;
    got_glb   = sel ? gl2 : gl1;
    got_flt   = sel ? ft2 : ft1;
    got_err   = sel ? er2 : er1;
    @(negedge clk);
    got_after = sel ? rs2 : rs1;
    chk(!got_busy_ready, "R1 ready low while busy", 64'(got_busy_ready), 64'd0);
    chk(!got_after, "R1 response is one cycle", 64'(got_after), 64'd0);
  endtask

  task automatic expect_fault(input string tag, input logic [3:0] code);
    chk(got_flt == 1'b1, tag, 64'(got_flt), 64'd1);
    chk(got_err == code, tag, 64'(got_err), 64'(code));
  endtask

  task automatic t_reset();
    chk(rr1 == 1'b1 && mv1 == 1'b0 && rs1 == 1'b0, "R1 reset state",
        64'({rr1, mv1, rs1}), 64'b100);
  endtask

  task automatic t_page4k();
    logic [63:0] leaf = 64'h12_3456_7000 | 64'h101;
    build(1'b0, 64'h2001, 64'h3021, 64'h4001, leaf);
    walk(1'b0);
    // R2 R3: correct frame only if every level used the right address and base
    chk(got_flt == 1'b0, "R2 R3 4k walk no fault", 64'(got_flt), 64'd0);
    chk(got_frame == 40'h12_3456_7000, "R4 4k frame", 64'(got_frame), 64'h12_3456_7000);
    chk(got_mask == 30'hfff, "R4 4k mask", 64'(got_mask), 64'hfff);
    chk(got_glb == 1'b1, "R10 global from leaf", 64'(got_glb), 64'd1);
    chk(u_mem.wr_count() == 2, "R11 write count", 64'(u_mem.wr_count()), 64'd2);
    chk(u_mem.wr_at(0) == longint'(ea(B3, LA, 3)), "R11 first write top level",
        64'(u_mem.wr_at(0)), 64'(ea(B3, LA, 3)));
    chk(u_mem.wr_at(1) == longint'(ea(B1, LA, 1)), "R11 second write level 1",
        64'(u_mem.wr_at(1)), 64'(ea(B1, LA, 1)));
    chk(u_mem.peek(longint'(ea(B3, LA, 3))) == 64'h2021, "R11 level 3 value",
        u_mem.peek(longint'(ea(B3, LA, 3))), 64'h2021);
    chk(u_mem.peek(longint'(ea(B0, LA, 0))) == leaf, "R11 leaf untouched",
        u_mem.peek(longint'(ea(B0, LA, 0))), leaf);
  endtask

  task automatic t_page2m();
    logic [PA_W-1:0] exp = 40'h8000_0000 | PA_W'(LA & 48'h1ff000);
    build(1'b0, 64'h2021, 64'h3001, 64'h8000_0000 | 64'ha1, 64'h0);
    walk(1'b0);
    chk(got_flt == 1'b0 && got_frame == exp, "R5 2m frame", 64'(got_frame), 64'(exp));
    chk(got_mask == 30'h1f_ffff, "R5 2m mask", 64'(got_mask), 64'h1fffff);
    chk(got_glb == 1'b0, "R10 global clear", 64'(got_glb), 64'd0);
    chk(u_mem.wr_count() == 1 && u_mem.wr_at(0) == longint'(ea(B2, LA, 2)),
        "R11 only level 2 written", 64'(u_mem.wr_count()), 64'd1);
  endtask

  task automatic t_rsvd2m();
    build(1'b0, 64'h2001, 64'h3001, 64'h8000_0000 | 64'h81 | 64'h2000, 64'h0);
    walk(1'b0);
    expect_fault("R5 2m reserved bit 13", 4'h9);
    chk(u_mem.wr_count() == 0, "R5 no write on fault", 64'(u_mem.wr_count()), 64'd0);
  endtask

  task automatic t_page1g();
    logic [PA_W-1:0] exp = 40'h4000_0000 | PA_W'(LA & 48'h3fff_f000);
    build(1'b0, 64'h2001, 64'h4000_0000 | 64'h1a1, 64'h0, 64'h0);
    walk(1'b0);
    chk(got_flt == 1'b0 && got_frame == exp, "R6 1g frame", 64'(got_frame), 64'(exp));
    chk(got_mask == 30'h3fff_ffff, "R6 1g mask", 64'(got_mask), 64'h3fffffff);
    chk(got_glb == 1'b1, "R10 1g global", 64'(got_glb), 64'd1);
    chk(u_mem.wr_count() == 1 && u_mem.wr_at(0) == longint'(ea(B3, LA, 3)),
        "R11 only level 3 written", 64'(u_mem.wr_count()), 64'd1);
  endtask

  task automatic t_rsvd1g();
    build(1'b0, 64'h2001, 64'h4000_0000 | 64'h81 | 64'h10_0000, 64'h0, 64'h0);
    walk(1'b0);
    expect_fault("R6 1g reserved bit 20", 4'h9);
  endtask

  task automatic t_ps_top();
    build(1'b0, 64'h2081, 64'h3001, 64'h4001, 64'h5001);
    walk(1'b0);
    expect_fault("R7 size bit at level 3", 4'h9);
  endtask

  task automatic t_not_present();
    build(1'b0, 64'h2001, 64'h3001, 64'h4000, 64'h5001);
    walk(1'b0);
    expect_fault("R8 not present", 4'h0);
    chk(u_mem.wr_count() == 0, "R8 no writes", 64'(u_mem.wr_count()), 64'd0);
    chk(u_mem.peek(longint'(ea(B3, LA, 3))) == 64'h2001, "R8 level 3 unchanged",
        u_mem.peek(longint'(ea(B3, LA, 3))), 64'h2001);
  endtask

  task automatic t_high_rsvd();
    build(1'b0, 64'h2001, 64'h3001 | (64'h1 << 45), 64'h4001, 64'h5001);
    walk(1'b0);
    expect_fault("R9 bit 45 above width", 4'h9);
  endtask

  task automatic t_no1g();
    build(1'b1, 64'h2001, 64'h4000_0000 | 64'h81, 64'h0, 64'h0);
    walk(1'b1);
    expect_fault("R6 1g disabled", 4'h9);
  endtask

  task automatic t_hold();
    chk(stall_seen > 0, "R12 stalls exercised", 64'(stall_seen), 64'd1);
    chk(hold_err == 0, "R12 request held", 64'(hold_err), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page4k();
    t_page2m();
    t_rsvd2m();
    t_page1g();
    t_rsvd1g();
    t_ps_top();
    t_not_present();
    t_high_rsvd();
    t_no1g();
    t_hold();
    finish_run();
  end
endmodule